// File: doc/BRIEF.md
# Synchronous Character Transmitter with Idle Fill

This block drives a synchronous serial line one character after another with no start or stop bits and no gaps. A bit-clock strobe goes out alongside the data bit, so the far end samples with the same timing reference that produced the data. The line is never silent. When the host has nothing to send at a character boundary, an idle character fills that whole character slot.

The host hands over bytes on a valid/ready port. Three qualifiers travel with each byte: the data, a start-of-message mark and an end-of-message mark. A byte marked as a message start is held back while a programmable number of sync characters goes out first. Between the first and last byte of a message, a slot that the host fails to fill counts as an under-run. It sets a sticky flag, which the host clears with a one-cycle pulse. Idle slots between messages do not count.

Top module: `sync_char_tx`

## Requirements
- R1: While reset is held and in the first clock after it, `underrunFlag` and `inReady` are 0. The first character sent after reset is the idle character.
- R2: Each character is CHAR_BITS (8) bits long, sent least significant bit first. Each bit lasts BIT_DIV clocks. `bitClkEn` is 1 only in the first clock of each bit period, and `serData` changes only in that clock.
- R3: Characters follow each other with no gap. Bit 0 of the next character starts in the clock right after the last bit period of the current one ends.
- R4: `inReady` can be 1 only in the final clock of the last bit period of a character. A byte taken with `inValid` and `inReady` both 1 is sent as the very next character.
- R5: A byte offered with `inSom`=1 is preceded by SYNC_COUNT (2) sync characters. The sync character is the parameter SYNC_CHAR, default 0x16. `inReady` stays 0 for that byte until the last sync character is under way.
- R6: At a boundary where no byte is taken and no sync character is due, the idle character is sent for the whole next slot. The idle character is the parameter IDLE_CHAR, default 0x16.
- R7: An idle slot inserted while a message is open sets `underrunFlag`, and the flag stays 1 until it is cleared. A message is open once a byte with `inLast`=0 has been taken, and it closes when a byte with `inLast`=1 is taken.
- R8: Idle slots outside an open message (after reset, or after a byte with `inLast`=1) leave `underrunFlag` unchanged.
- R9: A one-cycle pulse on `clrUnderrun` clears `underrunFlag` on the next clock. If an under-run is recorded on the same clock, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | CHAR_BITS | Host byte |
| inValid | input | 1 | Host byte is offered |
| inSom | input | 1 | Offered byte starts a message |
| inLast | input | 1 | Offered byte ends a message |
| inReady | output | 1 | Offered byte is taken this clock |
| clrUnderrun | input | 1 | Clears the under-run flag |
| serData | output | 1 | Serial data bit |
| bitClkEn | output | 1 | Bit clock strobe, first clock of each bit |
| underrunFlag | output | 1 | Sticky under-run indication |

## Verification
The bench decodes every character from the line and compares it with a character-level model of host offers. It runs directed cases first:
- a quiet line, which separates idle fill from false under-runs;
- a back-to-back message, which shows whether loading leaves a gap;
- a message with a hole, which must raise the flag;
- a single-byte message and a start mark in the middle of a message, which test sync insertion against a held start byte.

The idle character is overridden to differ from the sync character, so sync slots and idle slots can be told apart on the line. A seeded random phase then mixes offer gaps, message lengths and clear pulses, and checks `inReady` at every boundary.

// File: rtl/sync_char_tx_pkg.sv
package sync_char_tx_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_SYNC = 2'd1,
    CH_DATA = 2'd2
  } charSel_e;

  typedef struct packed {
    logic     shift;
    logic     load;
    charSel_e sel;
    logic     underrun;
  } txStrobe_t;
endpackage

// File: rtl/sync_char_tx_ctrl.sv
module sync_char_tx_ctrl
  import sync_char_tx_pkg::*;
#(
  parameter int CHAR_BITS  = 8,
  parameter int BIT_DIV    = 4,
  parameter int SYNC_COUNT = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inSom,
  input  logic      inLast,
  output logic      inReady,
  output logic      bitClkEn,
  output txStrobe_t strobe
);
  localparam int DIV_W  = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam int IDX_W  = (CHAR_BITS > 1) ? $clog2(CHAR_BITS) : 1;
  localparam int SYNC_W = $clog2(SYNC_COUNT + 1);

  logic [DIV_W-1:0]  divCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [SYNC_W-1:0] syncLeft;
  logic prefixDone, inMsg;
  logic bitTick, boundary, somPending, accept;

  always_comb begin
    bitTick    = (divCnt == DIV_W'(BIT_DIV - 1));
    boundary   = bitTick && (bitIdx == IDX_W'(CHAR_BITS - 1));
    somPending = inValid && inSom && !prefixDone;
    inReady    = boundary && (syncLeft == '0) && !(inSom && !prefixDone);
    accept     = inReady && inValid;
    bitClkEn   = (divCnt == '0);

    strobe          = '0;
    strobe.sel      = CH_IDLE;
    strobe.shift    = bitTick && !boundary;
    strobe.load     = boundary;
    if ((syncLeft != '0) || somPending) begin
      strobe.sel = CH_SYNC;
    end else if (accept) begin
      strobe.sel = CH_DATA;
    end else begin
      strobe.underrun = boundary && inMsg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      bitIdx     <= '0;
      syncLeft   <= '0;
      prefixDone <= 1'b0;
      inMsg      <= 1'b0;
    end else begin
      divCnt <= bitTick ? '0 : divCnt + 1'b1;
      if (boundary)     bitIdx <= '0;
      else if (bitTick) bitIdx <= bitIdx + 1'b1;
      if (boundary) begin
        if (syncLeft != '0) begin
          syncLeft <= syncLeft - 1'b1;
        end else if (somPending) begin
          syncLeft   <= SYNC_W'(SYNC_COUNT - 1);
          prefixDone <= 1'b1;
        end
      end
      if (accept) begin
        prefixDone <= 1'b0;
        inMsg      <= !inLast;
      end
    end
  end
endmodule

// File: rtl/sync_char_tx_datapath.sv
module sync_char_tx_datapath
  import sync_char_tx_pkg::*;
#(
  parameter int                 CHAR_BITS = 8,
  parameter logic [CHAR_BITS-1:0] SYNC_CHAR = 8'h16,
  parameter logic [CHAR_BITS-1:0] IDLE_CHAR = 8'h16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobe_t            strobe,
  input  logic [CHAR_BITS-1:0] inData,
  input  logic                 clrUnderrun,
  output logic                 serData,
  output logic                 underrunFlag
);
  logic [CHAR_BITS-1:0] shiftReg;
  logic [CHAR_BITS-1:0] nextChar;

  always_comb begin
    unique case (strobe.sel)
      CH_SYNC: nextChar = SYNC_CHAR;
      CH_DATA: nextChar = inData;
      default: nextChar = IDLE_CHAR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg     <= IDLE_CHAR;
      underrunFlag <= 1'b0;
    end else begin
      if (strobe.load)       shiftReg <= nextChar;
      else if (strobe.shift) shiftReg <= shiftReg >> 1;
      if (strobe.underrun)   underrunFlag <= 1'b1;
      else if (clrUnderrun)  underrunFlag <= 1'b0;
    end
  end

  assign serData = shiftReg[0];
endmodule

// File: rtl/sync_char_tx.sv
module sync_char_tx
  import sync_char_tx_pkg::*;
#(
  parameter int                   CHAR_BITS  = 8,
  parameter int                   BIT_DIV    = 4,
  parameter int                   SYNC_COUNT = 2,
  parameter logic [CHAR_BITS-1:0] SYNC_CHAR  = 8'h16,
  parameter logic [CHAR_BITS-1:0] IDLE_CHAR  = 8'h16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CHAR_BITS-1:0] inData,
  input  logic                 inValid,
  input  logic                 inSom,
  input  logic                 inLast,
  output logic                 inReady,
  input  logic                 clrUnderrun,
  output logic                 serData,
  output logic                 bitClkEn,
  output logic                 underrunFlag
);
  txStrobe_t strobe;

  sync_char_tx_ctrl #(
    .CHAR_BITS(CHAR_BITS), .BIT_DIV(BIT_DIV), .SYNC_COUNT(SYNC_COUNT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSom(inSom), .inLast(inLast),
    .inReady(inReady), .bitClkEn(bitClkEn), .strobe(strobe)
  );

  sync_char_tx_datapath #(
    .CHAR_BITS(CHAR_BITS), .SYNC_CHAR(SYNC_CHAR), .IDLE_CHAR(IDLE_CHAR)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .clrUnderrun(clrUnderrun), .serData(serData), .underrunFlag(underrunFlag)
  );
endmodule

// File: rtl/sync_char_tx_chk.sv
module sync_char_tx_chk #(
  parameter int BIT_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic clrUnderrun,
  input logic serData,
  input logic bitClkEn,
  input logic underrunFlag
);
  assert_ready_then_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> bitClkEn);

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !bitClkEn |-> $stable(serData));

  generate
    if (BIT_DIV > 1) begin : gStrobe
      assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rstN)
        bitClkEn |=> !bitClkEn);
    end
  endgenerate

  assert_flag_rise_at_boundary_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrunFlag) |-> bitClkEn);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (underrunFlag && !clrUnderrun) |=> underrunFlag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    clrUnderrun |=> (!underrunFlag || bitClkEn));
endmodule

bind sync_char_tx sync_char_tx_chk #(.BIT_DIV(BIT_DIV)) uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .clrUnderrun(clrUnderrun),
  .serData(serData), .bitClkEn(bitClkEn), .underrunFlag(underrunFlag)
);

// File: tb/tb_sync_char_tx.sv
`timescale 1ns/1ps
module tb_sync_char_tx;
  localparam int         NB    = 8;
  localparam int         DIV   = 4;
  localparam int         NSYNC = 2;
  localparam logic [7:0] SYNCC = 8'h16;
  localparam logic [7:0] IDLEC = 8'h3C;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inSom = 1'b0, inLast = 1'b0, clrUnderrun = 1'b0;
  logic inReady, serData, bitClkEn, underrunFlag;

  always #2.5 clk = ~clk;

  sync_char_tx #(.BIT_DIV(DIV), .SYNC_COUNT(NSYNC), .SYNC_CHAR(SYNCC), .IDLE_CHAR(IDLEC)) dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inSom(inSom),
    .inLast(inLast), .inReady(inReady), .clrUnderrun(clrUnderrun),
    .serData(serData), .bitClkEn(bitClkEn), .underrunFlag(underrunFlag)
  );

  int checks = 0, errors = 0;
  int syncLeftM = 0;
  bit prefixM = 0, inMsgM = 0, underM = 0;
  logic [7:0] expChar = IDLEC;
  string expTag = "R1";
  bit benchMsg = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One character slot; called at the negedge in its first clock.
  task automatic runChar(input bit v, input bit som, input bit last, input logic [7:0] d,
                         input bit clr, output bit acc);
    logic [7:0] got;
    bit expReady;
    logic [7:0] nxt;
    string nxtTag;
    got = '0;
    inValid = v; inSom = v & som; inLast = v & last; inData = d; clrUnderrun = clr;
    for (int b = 0; b < NB; b++) begin
      check(bitClkEn == 1'b1, "R2", "bit strobe at bit start", bitClkEn, 1);
      got[b] = serData;
      for (int k = 0; k < ((b < NB-1) ? DIV : DIV-1); k++) begin
        @(negedge clk);
        if (clrUnderrun) begin
          clrUnderrun = 1'b0;
          underM = 0;
          check(underrunFlag == 1'b0, "R9", "flag after clear", underrunFlag, 0);
        end
        if (k < DIV-1 || b == NB-1)
          check(inReady == 1'b0 || (b == NB-1 && k == DIV-2), "R4", "ready outside boundary", inReady, 0);
      end
    end
    // final clock of the last bit period: the boundary
    expReady = (syncLeftM == 0) && !(inSom && !prefixM);
    check(inReady == expReady, "R4", "ready at boundary", inReady, expReady);
    acc = inValid && inReady;
    if (syncLeftM != 0) begin
      nxt = SYNCC; nxtTag = "R5"; syncLeftM--;
    end else if (v && som && !prefixM) begin
      nxt = SYNCC; nxtTag = "R5"; syncLeftM = NSYNC - 1; prefixM = 1;
    end else if (v && expReady) begin
      nxt = d; nxtTag = "R4"; prefixM = 0; inMsgM = !last;
    end else begin
      nxt = IDLEC; nxtTag = "R6";
      if (inMsgM) underM = 1;
    end
    check(got == expChar, expTag, "character on line (R3 no gap)", got, expChar);
    @(negedge clk);
    expChar = nxt; expTag = nxtTag;
    check(underrunFlag == underM, inMsgM ? "R7" : "R8", "underrun flag", underrunFlag, underM);
  endtask

  task automatic offer(input logic [7:0] d, input bit som, input bit last);
    bit acc;
    acc = 0;
    while (!acc) runChar(1'b1, som, last, d, 1'b0, acc);
  endtask

  task automatic gap(input int n, input bit clr);
    bit acc;
    for (int i = 0; i < n; i++) runChar(1'b0, 1'b0, 1'b0, 8'h00, clr && (i == 0), acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit pend, pSom, pLast, acc;
    logic [7:0] pData;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(underrunFlag == 1'b0, "R1", "flag in reset", underrunFlag, 0);
    check(inReady == 1'b0, "R1", "ready in reset", inReady, 0);
    rstN = 1'b1;
    check(underrunFlag == 1'b0 && inReady == 1'b0, "R1", "outputs after reset", {underrunFlag, inReady}, 0);

    // R6/R8: quiet line carries idle, no under-run
    gap(2, 1'b0);
    // R5/R3: three-byte message back to back
    offer(8'hA5, 1, 0); offer(8'h5A, 0, 0); offer(8'hC3, 0, 1);
    gap(1, 1'b0);
    // R7: hole inside a message, then sticky through idle
    offer(8'h81, 1, 0); gap(1, 1'b0); offer(8'h7E, 0, 1);
    gap(2, 1'b0);
    // R9: clear between messages, R8: idle afterwards keeps it clear
    gap(2, 1'b1);
    // single-byte message
    offer(8'hFF, 1, 1);
    // R5: start mark in the middle of an open message
    offer(8'h01, 1, 0); offer(8'h02, 1, 0); offer(8'h03, 0, 1);
    gap(1, 1'b1);

    // random phase
    pend = 0; pSom = 0; pLast = 0; pData = '0;
    for (int i = 0; i < 150; i++) begin
      if (!pend && ($urandom % 100) < 60) begin
        pend = 1; pData = 8'($urandom);
        pSom = !benchMsg || (($urandom % 100) < 5);
        pLast = ($urandom % 100) < 30;
      end
      runChar(pend, pSom, pLast, pData, ($urandom % 100) < 10, acc);
      if (acc) begin
        pend = 0;
        benchMsg = !pLast;
      end
    end
    summary();
    $finish;
  end
endmodule